// File: doc/BRIEF.md
# Boot Descriptor Source Selector

This block runs once after each reset. It picks the device's operating mode and the USB identity values it will use: vendor ID, product ID and device ID. Three sources can supply the identity values. An external EEPROM is used when one is present. Otherwise a fused identity word is used. If the fused word is blank, a fixed default set is used. A strap on the ATA reset pin can force a board-level test mode.

The block does not talk to the EEPROM, read the fuses or enumerate on USB. Each of those steps is done elsewhere and hands its result in through a level-valued "done" flag and data lines. The pin level passes through a synchronizer and is latched once, shortly after reset is released. The block then waits until both upstream steps report done. At that point it registers its choice, pulses a one-cycle strobe, and holds the result until the next reset.

Top module: `boot_id_select`

## Requirements
- R1: If the strap pin `ata_rst_n_i` is low when it is latched after reset, the reported mode is board test (2'b01). This holds whatever the EEPROM and fuse inputs are. The identity values still come from the EEPROM if one is present, else from the fuse word if it is non-zero, else from the defaults.
- R2: With the strap high and `eeprom_present_i` high, the mode is normal (2'b00) and the identity values come from the EEPROM inputs. This holds even when the fuse word is all zero.
- R3: With the strap high and no EEPROM, a non-zero fuse word gives mode normal (2'b00). The fuse word is split as vendor ID = bits [47:32], product ID = bits [31:16] and device ID = bits [15:0]. A single set bit makes the word valid.
- R4: With the strap high, no EEPROM and an all-zero fuse word, the mode is manufacturing default (2'b10). The outputs are vendor ID 16'h04B4, product ID 16'h6830 and device ID 16'h0000.
- R5: The pin passes through a two-flop synchronizer and is latched once, two clock edges after reset release. Any later change of the pin has no effect on the result.
- R6: No decision is taken and no strobe is given until both `eeprom_done_i` and `fuse_done_i` are high. Either one alone is not enough.
- R7: `done_o` is high for exactly one cycle, and only once per reset.
- R8: After the decision, the mode and identity outputs hold their values until the next reset, even when every input changes.
- R9: From reset until the decision, the mode reads 2'b11 (pending) and all identity outputs read zero. Board test is therefore never shown as normal mode, not even before the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ata_rst_n_i | input | 1 | Asynchronous strap pin level; low selects board test |
| eeprom_done_i | input | 1 | EEPROM probe has finished |
| eeprom_present_i | input | 1 | An EEPROM answered the probe |
| eeprom_vid_i | input | 16 | Vendor ID read from the EEPROM |
| eeprom_pid_i | input | 16 | Product ID read from the EEPROM |
| eeprom_did_i | input | 16 | Device ID read from the EEPROM |
| fuse_done_i | input | 1 | Fuse read has finished |
| fuse_word_i | input | 48 | Fused identity word {vendor, product, device} |
| mode_o | output | 2 | 00 normal, 01 board test, 10 manufacturing default, 11 pending |
| vid_o | output | 16 | Selected vendor ID |
| pid_o | output | 16 | Selected product ID |
| did_o | output | 16 | Selected device ID |
| done_o | output | 1 | One-cycle strobe when the selection is made |

## Verification
The bench drives a fuse word that is zero except for its lowest bit. A design that tests only the upper fields for zero would then wrongly fall back to the defaults. It combines the strap with a present EEPROM, and with a blank fuse word. A wrong priority would then report normal or manufacturing mode instead of board test. It also moves the pin after the latch point, and raises only one of the two done flags. A design that samples continuously, or that decides early, would change the mode or pulse too soon. Finally, it changes every input after the strobe. This catches outputs that follow their sources, or a strobe that fires again.

// File: rtl/boot_id_pkg.sv
package boot_id_pkg;

    localparam int unsigned ID_W = 16;

    typedef enum logic [1:0] {
        MODE_NORMAL      = 2'b00,
        MODE_BOARD_TEST  = 2'b01,
        MODE_MFG_DEFAULT = 2'b10,
        MODE_PENDING     = 2'b11
    } boot_mode_e;

    typedef struct packed {
        logic [ID_W-1:0] vid;
        logic [ID_W-1:0] pid;
        logic [ID_W-1:0] did;
    } id_set_t;

    localparam int unsigned ID_SET_W = $bits(id_set_t);

endpackage

// File: rtl/boot_strap_sampler.sv
module boot_strap_sampler #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_n_i,
    output logic strap_valid_o,
    output logic strap_low_o
);
    localparam int unsigned CNT_W = $clog2(SYNC_STAGES + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   valid;
        logic                   low;
    } samp_t;

    samp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // shift chain: stage 0 takes the raw pin
        st_d.sync[0] = pin_n_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        if (!st_q.valid) begin
            if (st_q.cnt == CNT_W'(SYNC_STAGES)) begin
                st_d.valid = 1'b1;
                st_d.low   = ~st_q.sync[SYNC_STAGES-1];
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sync  <= '1;
            st_q.cnt   <= '0;
            st_q.valid <= 1'b0;
            st_q.low   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strap_valid_o = st_q.valid;
    assign strap_low_o   = st_q.low;

    // once latched, the strap never changes again
    assert_strap_latched_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strap_valid_o |=> (strap_valid_o && $stable(strap_low_o)));

endmodule

// File: rtl/boot_id_arbiter.sv
module boot_id_arbiter
    import boot_id_pkg::*;
#(
    parameter logic [ID_W-1:0] DEF_VID = 16'h04B4,
    parameter logic [ID_W-1:0] DEF_PID = 16'h6830,
    parameter logic [ID_W-1:0] DEF_DID = 16'h0000
) (
    input  logic       strap_low_i,
    input  logic       eeprom_present_i,
    input  id_set_t    eeprom_id_i,
    input  id_set_t    fuse_id_i,
    output boot_mode_e mode_o,
    output id_set_t    id_o
);
    logic fuse_blank;
    id_set_t def_id;

    assign def_id     = '{vid: DEF_VID, pid: DEF_PID, did: DEF_DID};
    assign fuse_blank = (fuse_id_i == '0);

    always_comb begin
        // identity source: EEPROM, then fuses, then defaults
        if (eeprom_present_i) begin
            id_o = eeprom_id_i;
        end else if (!fuse_blank) begin
            id_o = fuse_id_i;
        end else begin
            id_o = def_id;
        end
        // mode: strap wins over everything
        if (strap_low_i) begin
            mode_o = MODE_BOARD_TEST;
        end else if (eeprom_present_i || !fuse_blank) begin
            mode_o = MODE_NORMAL;
        end else begin
            mode_o = MODE_MFG_DEFAULT;
        end
    end

endmodule

// File: rtl/boot_id_select.sv
module boot_id_select
    import boot_id_pkg::*;
#(
    parameter logic [ID_W-1:0] DEF_VID     = 16'h04B4,
    parameter logic [ID_W-1:0] DEF_PID     = 16'h6830,
    parameter logic [ID_W-1:0] DEF_DID     = 16'h0000,
    parameter int unsigned     SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                ata_rst_n_i,
    input  logic                eeprom_done_i,
    input  logic                eeprom_present_i,
    input  logic [ID_W-1:0]     eeprom_vid_i,
    input  logic [ID_W-1:0]     eeprom_pid_i,
    input  logic [ID_W-1:0]     eeprom_did_i,
    input  logic                fuse_done_i,
    input  logic [ID_SET_W-1:0] fuse_word_i,
    output logic [1:0]          mode_o,
    output logic [ID_W-1:0]     vid_o,
    output logic [ID_W-1:0]     pid_o,
    output logic [ID_W-1:0]     did_o,
    output logic                done_o
);
    typedef struct packed {
        logic       decided;
        logic       done;
        boot_mode_e mode;
        id_set_t    id;
    } sel_t;

    logic       strap_valid, strap_low;
    boot_mode_e arb_mode;
    id_set_t    arb_id, eeprom_id, fuse_id;
    sel_t       st_d, st_q;

    assign eeprom_id = '{vid: eeprom_vid_i, pid: eeprom_pid_i, did: eeprom_did_i};
    assign fuse_id   = id_set_t'(fuse_word_i);

    boot_strap_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .pin_n_i       (ata_rst_n_i),
        .strap_valid_o (strap_valid),
        .strap_low_o   (strap_low)
    );

    boot_id_arbiter #(.DEF_VID(DEF_VID), .DEF_PID(DEF_PID), .DEF_DID(DEF_DID)) i_arbiter (
        .strap_low_i      (strap_low),
        .eeprom_present_i (eeprom_present_i),
        .eeprom_id_i      (eeprom_id),
        .fuse_id_i        (fuse_id),
        .mode_o           (arb_mode),
        .id_o             (arb_id)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.decided && strap_valid && eeprom_done_i && fuse_done_i) begin
            st_d.decided = 1'b1;
            st_d.done    = 1'b1;
            st_d.mode    = arb_mode;
            st_d.id      = arb_id;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.decided <= 1'b0;
            st_q.done    <= 1'b0;
            st_q.mode    <= MODE_PENDING;
            st_q.id      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign vid_o  = st_q.id.vid;
    assign pid_o  = st_q.id.pid;
    assign did_o  = st_q.id.did;
    assign done_o = st_q.done;

    assert_strap_mode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (strap_low == (mode_o == MODE_BOARD_TEST)));

    assert_wait_both_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(eeprom_done_i && fuse_done_i && strap_valid));

    assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_hold_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.decided |=> ($stable(mode_o) && $stable(vid_o) && $stable(pid_o)
                          && $stable(did_o) && !done_o));

    assert_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.decided |-> (mode_o == MODE_PENDING && vid_o == '0 && !done_o));

endmodule

// File: tb/test_boot_id_select.sv
module test_boot_id_select;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        pin;
        logic        eep;
        logic [47:0] eep_id;
        logic [47:0] fuse;
        logic [1:0]  exp_mode;
        logic [47:0] exp_id;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b1, 48'h1111_2222_3333, 48'h0, 2'b00, 48'h1111_2222_3333},
        '{1'b1, 1'b0, 48'h1111_2222_3333, 48'hAAAA_BBBB_CCCC, 2'b00, 48'hAAAA_BBBB_CCCC},
        '{1'b1, 1'b0, 48'h1111_2222_3333, 48'h0, 2'b10, 48'h04B4_6830_0000},
        '{1'b0, 1'b1, 48'h4444_5555_6666, 48'hAAAA_BBBB_CCCC, 2'b01, 48'h4444_5555_6666},
        '{1'b0, 1'b0, 48'h4444_5555_6666, 48'h0, 2'b01, 48'h04B4_6830_0000},
        '{1'b1, 1'b0, 48'h4444_5555_6666, 48'h0000_0000_0001, 2'b00, 48'h0000_0000_0001},
        '{1'b0, 1'b0, 48'h4444_5555_6666, 48'h1234_5678_9ABC, 2'b01, 48'h1234_5678_9ABC}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b1;
    logic        eep_done = 1'b0, eep_present = 1'b0, fuse_done = 1'b0;
    logic [47:0] eep_id = '0, fuse = '0;
    logic [1:0]  mode;
    logic [15:0] vid, pid, did;
    logic        done;

    int checks = 0, errors = 0, pulses = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_id_select i_boot_id_select (
        .clk_i(clk), .rst_ni(rst_n), .ata_rst_n_i(pin),
        .eeprom_done_i(eep_done), .eeprom_present_i(eep_present),
        .eeprom_vid_i(eep_id[47:32]), .eeprom_pid_i(eep_id[31:16]), .eeprom_did_i(eep_id[15:0]),
        .fuse_done_i(fuse_done), .fuse_word_i(fuse),
        .mode_o(mode), .vid_o(vid), .pid_o(pid), .did_o(did), .done_o(done)
    );

    always @(negedge clk) if (done) pulses++;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic start(input logic p, input logic e, input logic [47:0] eid, input logic [47:0] f);
        @(negedge clk);
        rst_n = 1'b0; eep_done = 1'b0; fuse_done = 1'b0;
        pin = p; eep_present = e; eep_id = eid; fuse = f;
        repeat (3) @(negedge clk);
        pulses = 0;
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        bit seen;
        string req;
        // R9: reset state
        repeat (2) @(negedge clk);
        check("R9 mode in reset", 64'(mode), 64'(2'b11));
        check("R9 ids in reset", {16'h0, vid, pid, did}, 64'h0);

        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v].exp_mode == 2'b01) req = "R1";
            else if (VEC[v].exp_mode == 2'b10) req = "R4";
            else if (VEC[v].eep) req = "R2";
            else req = "R3";
            start(VEC[v].pin, VEC[v].eep, VEC[v].eep_id, VEC[v].fuse);
            check("R9 pending before decision", 64'(mode), 64'(2'b11));
            eep_done = 1'b1; fuse_done = 1'b1;
            wait_done(seen);
            check({req, " done seen"}, 64'(seen), 64'd1);
            check({req, " mode"}, 64'(mode), 64'(VEC[v].exp_mode));
            check({req, " ids"}, 64'({vid, pid, did}), 64'(VEC[v].exp_id));
            @(negedge clk);
            check("R7 done low next cycle", 64'(done), 64'd0);
            // R8: every input moves after the decision
            pin = ~pin; eep_present = ~eep_present; eep_id = ~eep_id; fuse = ~fuse;
            eep_done = 1'b0; fuse_done = 1'b0;
            repeat (10) @(negedge clk);
            check("R8 mode held", 64'(mode), 64'(VEC[v].exp_mode));
            check("R8 ids held", 64'({vid, pid, did}), 64'(VEC[v].exp_id));
            check("R7 single pulse", 64'(pulses), 64'd1);
        end

        // R6: only one done flag raised
        start(1'b1, 1'b1, 48'h1111_2222_3333, 48'h0);
        eep_done = 1'b1;
        repeat (20) @(negedge clk);
        check("R6 no decision with eeprom_done only", 64'(pulses), 64'd0);
        check("R6 still pending", 64'(mode), 64'(2'b11));
        eep_done = 1'b0; fuse_done = 1'b1;
        repeat (20) @(negedge clk);
        check("R6 no decision with fuse_done only", 64'(pulses), 64'd0);
        eep_done = 1'b1;
        wait_done(seen);
        check("R6 decision once both high", 64'(seen), 64'd1);

        // R5: pin rises after the latch point, strap stays board test
        start(1'b0, 1'b1, 48'h1111_2222_3333, 48'h0);
        pin = 1'b1;
        repeat (5) @(negedge clk);
        eep_done = 1'b1; fuse_done = 1'b1;
        wait_done(seen);
        check("R5 late pin rise ignored", 64'(mode), 64'(2'b01));

        // R5: pin falls after the latch point, mode stays normal
        start(1'b1, 1'b1, 48'h1111_2222_3333, 48'h0);
        pin = 1'b0;
        repeat (5) @(negedge clk);
        eep_done = 1'b1; fuse_done = 1'b1;
        wait_done(seen);
        check("R5 late pin fall ignored", 64'(mode), 64'(2'b00));

        summary();
    end
endmodule